// File: doc/BRIEF.md
# HDLC Receive Line Status Monitor

This block watches the serial data line of an HDLC receiver and reports, in real time, whether a flag sequence is currently on the line and whether the line has gone idle. The line is sampled once per receive bit, signalled by a one-cycle bit strobe in the system clock domain. A flag is the eight-bit pattern 01111110. The line counts as idle once a run of consecutive ones reaches a fixed length, 15 by default.

Two read-only 8-bit registers carry the results. The status register shows the live flag-status and idle-status bits. The event register holds sticky event bits, and software clears them by writing ones. The flag event is raised each time flag reception begins and each time it ends, so a flag period surrounding a frame produces two events. The idle event is raised once each time the line enters idle. Zero-bit deletion, frame assembly, CRC checking and the modem control lines are handled elsewhere.

Top module: `hdlc_rx_line_mon`

## Requirements
- R1: After reset, both registers read 0x00.
- R2: When the bit sampled on a strobe completes the pattern 0,1,1,1,1,1,1,0 over the last eight sampled bits, status bit 1 (flag status) reads 1 after that clock edge.
- R3: Flag status stays set across back-to-back flags that share a zero. It clears on the first sampled bit that cannot continue a flag: a zero that does not complete the pattern, or a seventh consecutive one.
- R4: Status bit 0 (idle status) sets on the strobe that samples the 15th consecutive one. It stays set while ones continue, and any sampled zero clears it.
- R5: Event bit 1 (flag event) sets on the same edge as every rise and every fall of flag status.
- R6: Event bit 0 (idle event) sets once when idle status rises. Further ones while idle do not set it again, and idle status clearing does not set it.
- R7: Pulsing the clear strobe with a mask clears each event bit whose mask bit is 1. Mask bits that are 0, and mask bits 7:2, have no effect. If a bit is set and cleared on the same edge, it ends up set.
- R8: Bits 7:2 of both registers always read 0.
- R9: When the bit strobe is low, the data line is ignored and neither register changes, except through a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | One-cycle strobe: sample `rxd` on this edge |
| rxd | input | 1 | Serial receive data |
| evt_clr_we | input | 1 | Write strobe for event clear |
| evt_clr_mask | input | 8 | Write-one-to-clear mask for the event register |
| status_rd | output | 8 | Status register: bit 1 flag status, bit 0 idle status |
| event_rd | output | 8 | Event register: bit 1 flag event, bit 0 idle event |

## Verification
The bench targets back-to-back flags that share a zero. A design that dropped and re-raised the flag status there would post spurious flag events. It also drives runs of exactly 14, 15 and 16 ones. An off-by-one counter would declare idle one bit early or late, and a counter that did not saturate would raise the idle event again. A set and a clear land on the same edge, which catches a design that lets the clear win. A flag followed by a seventh one exposes a design that keeps flag status during an abort, and toggling data with the strobe low catches a design that samples without the enable.

// File: rtl/hdlc_mon_pkg.sv
package hdlc_mon_pkg;
  localparam int          REG_W     = 8;
  localparam int          PAT_W     = 8;
  localparam logic [7:0]  FLAG_PAT  = 8'h7E;
  localparam int          FLAG_ONES = 6;
  localparam int          N_EVT     = 2;
  localparam int          IDLE_BIT  = 0;
  localparam int          FLAG_BIT  = 1;
endpackage

// File: rtl/hdlc_ones_run.sv
module hdlc_ones_run #(
  parameter int IDLE_RUN = 15,
  parameter int CNT_W    = $clog2(IDLE_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rxd,
  output logic [CNT_W-1:0] ones_cnt,
  output logic             idle_st,
  output logic             idle_rise
);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(IDLE_RUN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             idle_q, idle_d;

  always_comb begin
    cnt_d = cnt_q;
    if (bit_en) begin
      if (!rxd)                cnt_d = '0;
      else if (cnt_q != RUN_MAX) cnt_d = cnt_q + 1'b1;
    end
    idle_d    = (cnt_d == RUN_MAX);
    idle_rise = idle_d & ~idle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (bit_en) begin
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
    end
  end

  assign ones_cnt = cnt_q;
  assign idle_st  = idle_q;

  AST_IDLE_DROP_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !rxd) |=> !idle_q); // R4
  AST_RUN_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(cnt_q) && $stable(idle_q))); // R9
endmodule

// File: rtl/hdlc_flag_track.sv
module hdlc_flag_track
  import hdlc_mon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rxd,
  input  logic [CNT_W-1:0] ones_cnt,
  output logic             flag_st,
  output logic             flag_chg
);
  localparam logic [CNT_W-1:0] ONES_LIM = CNT_W'(FLAG_ONES);

  logic [PAT_W-2:0] hist_q, hist_d;
  logic [PAT_W-1:0] window;
  logic             match;
  logic             flag_q, flag_d;

  always_comb begin
    window = {rxd, hist_q};
    match  = (window == FLAG_PAT);
    hist_d = hist_q;
    flag_d = flag_q;
    if (bit_en) begin
      hist_d = window[PAT_W-1:1];
      if (match)                            flag_d = 1'b1;
      else if (!rxd)                        flag_d = 1'b0;
      else if (ones_cnt >= ONES_LIM)        flag_d = 1'b0;
    end
    flag_chg = bit_en & (flag_d ^ flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      flag_q <= 1'b0;
    end else if (bit_en) begin
      hist_q <= hist_d;
      flag_q <= flag_d;
    end
  end

  assign flag_st = flag_q;

  AST_MATCH_AFTER_SIX_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && match) |-> (ones_cnt == ONES_LIM)); // R2
  AST_FLAG_DROP_LONG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && rxd && ones_cnt >= ONES_LIM) |=> !flag_q); // R3
endmodule

// File: rtl/hdlc_evt_sticky.sv
module hdlc_evt_sticky #(
  parameter int N_EVT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_vec,
  input  logic             clr_we,
  input  logic [N_EVT-1:0] clr_mask,
  output logic [N_EVT-1:0] evt_q
);
  logic [N_EVT-1:0] evt_d;

  for (genvar i = 0; i < N_EVT; i++) begin : g_evt
    always_comb begin
      evt_d[i] = set_vec[i] | (evt_q[i] & ~(clr_we & clr_mask[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q[i] <= 1'b0;
      else        evt_q[i] <= evt_d[i];
    end
  end

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((evt_q & $past(set_vec)) == $past(set_vec))); // R7
  AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R7
endmodule

// File: rtl/hdlc_rx_line_mon.sv
module hdlc_rx_line_mon
  import hdlc_mon_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rxd,
  input  logic             evt_clr_we,
  input  logic [REG_W-1:0] evt_clr_mask,
  output logic [REG_W-1:0] status_rd,
  output logic [REG_W-1:0] event_rd
);
  localparam int CNT_W = $clog2(IDLE_RUN + 1);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [CNT_W-1:0] ones_cnt;
  logic             idle_st, idle_rise;
  logic             flag_st, flag_chg;
  logic [N_EVT-1:0] set_vec;
  logic [N_EVT-1:0] evt_q;
  logic             unused_mask_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  hdlc_ones_run #(.IDLE_RUN(IDLE_RUN), .CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_sync_n), .bit_en(bit_en), .rxd(rxd),
    .ones_cnt(ones_cnt), .idle_st(idle_st), .idle_rise(idle_rise)
  );

  hdlc_flag_track #(.CNT_W(CNT_W)) u_flag (
    .clk(clk), .rst_n(rst_sync_n), .bit_en(bit_en), .rxd(rxd),
    .ones_cnt(ones_cnt), .flag_st(flag_st), .flag_chg(flag_chg)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[IDLE_BIT] = idle_rise;
    set_vec[FLAG_BIT] = flag_chg;
  end

  hdlc_evt_sticky #(.N_EVT(N_EVT)) u_evt (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec),
    .clr_we(evt_clr_we), .clr_mask(evt_clr_mask[N_EVT-1:0]), .evt_q(evt_q)
  );

  assign unused_mask_hi = ^evt_clr_mask[REG_W-1:N_EVT];

  always_comb begin
    status_rd           = '0;
    status_rd[IDLE_BIT] = idle_st;
    status_rd[FLAG_BIT] = flag_st;
    event_rd                = '0;
    event_rd[N_EVT-1:0]     = evt_q;
  end

  AST_FLAG_EVT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(status_rd[FLAG_BIT]) |-> event_rd[FLAG_BIT]); // R5
  AST_IDLE_EVT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(status_rd[IDLE_BIT]) |-> event_rd[IDLE_BIT]); // R6
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_rd[REG_W-1:2] == '0) && (event_rd[REG_W-1:2] == '0)); // R8
endmodule

// File: tb/hdlc_rx_line_mon_tb.sv
module hdlc_rx_line_mon_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, rxd, evt_clr_we;
  logic [7:0] evt_clr_mask;
  logic [7:0] status_rd, event_rd;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [6:0] m_hist;
  int         m_ones;
  logic       m_flag, m_idle;
  logic [1:0] m_evt;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_line_mon u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rxd(rxd),
    .evt_clr_we(evt_clr_we), .evt_clr_mask(evt_clr_mask),
    .status_rd(status_rd), .event_rd(event_rd)
  );

  function automatic logic [7:0] exp_status();
    return {6'b0, m_flag, m_idle};
  endfunction

  function automatic logic [7:0] exp_events();
    return {6'b0, m_evt};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hist = '0; m_ones = 0; m_flag = 0; m_idle = 0; m_evt = '0;
  endtask

  // One clock cycle: drive at negedge, update model, check at next negedge.
  task automatic cyc(input bit en, input bit b, input bit we, input logic [7:0] mask, input string tag);
    logic [7:0] win;
    logic [1:0] setv;
    bit nflag, nidle;
    int nones;
    @(negedge clk);
    bit_en = en; rxd = b; evt_clr_we = we; evt_clr_mask = mask;
    setv = '0;
    if (en) begin
      win   = {b, m_hist};
      nones = b ? ((m_ones < 15) ? m_ones + 1 : 15) : 0;
      nidle = (nones == 15);
      nflag = (win == 8'h7E) || (m_flag && b && nones <= 6);
      setv[0] = nidle && !m_idle;
      setv[1] = nflag != m_flag;
      m_hist = win[7:1]; m_ones = nones; m_flag = nflag; m_idle = nidle;
    end
    if (we) m_evt = m_evt & ~mask[1:0];
    m_evt = m_evt | setv;
    @(negedge clk);
    bit_en = 0; evt_clr_we = 0; evt_clr_mask = '0;
    chk(status_rd == exp_status(), tag, status_rd, exp_status());
    chk(event_rd == exp_events(), tag, event_rd, exp_events());
  endtask

  task automatic send(input bit b, input string tag);
    cyc(1'b1, b, 1'b0, 8'h00, tag);
  endtask

  task automatic send_flag(input string tag);
    send(1'b0, tag);
    for (int i = 0; i < 6; i++) send(1'b1, tag);
    send(1'b0, tag);
  endtask

  task automatic clear_all();
    cyc(1'b0, 1'b0, 1'b1, 8'hFF, "R7");
  endtask

  task automatic do_reset();
    rst_n = 0; bit_en = 0; rxd = 0; evt_clr_we = 0; evt_clr_mask = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 0x01 expected 0x00");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R1 / R8: reset values
    chk(status_rd == 8'h00, "R1", status_rd, 8'h00);
    chk(event_rd == 8'h00, "R1", event_rd, 8'h00);

    // R2 / R5: single flag
    send_flag("R2");
    chk(status_rd[1] == 1'b1, "R2", status_rd, 8'h02);
    chk(event_rd[1] == 1'b1, "R5", event_rd, 8'h02);
    clear_all();
    chk(event_rd == 8'h00, "R7", event_rd, 8'h00);

    // R3: back-to-back flag sharing a zero keeps flag, no new event
    for (int i = 0; i < 6; i++) send(1'b1, "R3");
    send(1'b0, "R3");
    chk(status_rd[1] == 1'b1, "R3", status_rd, 8'h02);
    chk(event_rd == 8'h00, "R5", event_rd, 8'h00);

    // R3 / R5: data zero after short run ends flag
    send(1'b1, "R3");
    send(1'b0, "R3");
    chk(status_rd[1] == 1'b0, "R3", status_rd, 8'h00);
    chk(event_rd[1] == 1'b1, "R5", event_rd, 8'h02);
    clear_all();

    // R3: seventh consecutive one aborts flag
    send_flag("R3");
    clear_all();
    for (int i = 0; i < 6; i++) send(1'b1, "R3");
    chk(status_rd[1] == 1'b1, "R3", status_rd, 8'h02);
    send(1'b1, "R3");
    chk(status_rd[1] == 1'b0, "R3", status_rd, 8'h00);
    chk(event_rd[1] == 1'b1, "R5", event_rd, 8'h02);
    clear_all();

    // R4 / R6: idle at exactly 15 ones
    send(1'b0, "R4");
    for (int i = 0; i < 14; i++) send(1'b1, "R4");
    chk(status_rd[0] == 1'b0, "R4", status_rd, 8'h00);
    send(1'b1, "R4");
    chk(status_rd[0] == 1'b1, "R4", status_rd, 8'h01);
    chk(event_rd[0] == 1'b1, "R6", event_rd, 8'h01);
    clear_all();
    for (int i = 0; i < 5; i++) send(1'b1, "R6");
    chk(event_rd == 8'h00, "R6", event_rd, 8'h00);
    chk(status_rd[0] == 1'b1, "R4", status_rd, 8'h01);

    // R9: strobe low, data toggles, nothing moves
    for (int i = 0; i < 8; i++) cyc(1'b0, i[0], 1'b0, 8'h00, "R9");
    chk(status_rd == 8'h01, "R9", status_rd, 8'h01);

    send(1'b0, "R4");
    chk(status_rd[0] == 1'b0, "R4", status_rd, 8'h00);
    chk(event_rd == 8'h00, "R6", event_rd, 8'h00);

    // R7: set and clear on the same edge, set wins
    for (int i = 0; i < 14; i++) send(1'b1, "R7");
    cyc(1'b1, 1'b1, 1'b1, 8'h01, "R7");
    chk(event_rd[0] == 1'b1, "R7", event_rd, 8'h01);

    // R7 / R8: writes of zero and of upper bits have no effect
    send(1'b0, "R7");
    send_flag("R7");
    cyc(1'b0, 1'b0, 1'b1, 8'hFC, "R7");
    chk(event_rd == 8'h03, "R7", event_rd, 8'h03);
    cyc(1'b0, 1'b0, 1'b1, 8'h00, "R7");
    chk(event_rd == 8'h03, "R8", event_rd, 8'h03);
    cyc(1'b0, 1'b0, 1'b1, 8'h02, "R7");
    chk(event_rd == 8'h01, "R7", event_rd, 8'h01);
    clear_all();

    // Random traffic with embedded flags and idle runs, random clears
    for (int n = 0; n < 4000; n++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      if (sel < 6) begin
        send_flag("R2");
      end else if (sel < 8) begin
        for (int k = 0; k < 16; k++) send(1'b1, "R4");
      end else if (sel < 15) begin
        cyc(1'b0, 1'($urandom), 1'($urandom), 8'($urandom), "R9");
      end else begin
        cyc(1'b1, ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0),
            8'($urandom), "R3");
      end
    end

    // R1: reset mid-run returns to zero
    send_flag("R1");
    do_reset();
    chk(status_rd == 8'h00, "R1", status_rd, 8'h00);
    chk(event_rd == 8'h00, "R1", event_rd, 8'h00);

    finish_run();
  end
endmodule